// File: doc/BRIEF.md
# One-Hot Residue Arithmetic Unit

This block adds, subtracts and multiplies integers held in residue form over the fixed co-prime moduli 3, 5 and 7. Every channel carries its residue as a one-hot word, with one bit for each possible value. A channel's arithmetic is therefore only a rewiring of the operand's bits: a rotation for sum and difference, and a permutation for product. No carry passes from one channel to another. Because the three moduli share no factor, the channel results together stand for exactly one integer in 0 to 104. Results wrap modulo 105.

The unit also has a binary loader, which turns a plain binary word into the three one-hot residues. A Chinese-remainder rebuilder then turns each registered result back into binary. A caller sets the operands and the operation, then raises `start_i` for one cycle. One cycle later the unit raises `done_o`, and the one-hot result, its binary value and the per-channel error flags stay registered until the next start.

Top module: `ohrns_alu`

## Requirements
- R1: While `rst_ni` is low, `done_o` and `err_o` are 0, `val_o` is 0, and `res_o` is 15'h109, which is residue 0 in every channel.
- R2: `done_o` is 1 in the cycle after each cycle in which `start_i` was sampled high, and 0 after every cycle in which it was sampled low.
- R3: With `op_i` = 0, each channel result is (a + b) mod m. The channel for modulus 3 sits in bits [2:0], modulus 5 in bits [7:3] and modulus 7 in bits [14:8]. Residue r is marked by bit r of its field.
- R4: With `op_i` = 1, each channel result is (a − b) mod m.
- R5: With `op_i` = 2, each channel result is (a · b) mod m. A zero operand gives residue 0.
- R6: With `op_i` = 3, channel i loads `bin_i` mod m_i, `err_o` stays 0, and `a_i` and `b_i` have no effect.
- R7: `val_o` is the one integer in 0..104 whose residues mod 3, 5 and 7 equal the registered channel results.
- R8: For `op_i` 0 to 2, a channel whose field in `a_i` or `b_i` does not have exactly one bit set raises its own `err_o` bit: bit 0 for modulus 3, bit 1 for modulus 5, bit 2 for modulus 7. That channel's result is forced to residue 0, and the other channels are computed as usual.
- R9: While `start_i` is low, `res_o`, `val_o` and `err_o` keep their values.
- R10: Every channel field of `res_o` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one operation |
| op_i | input | 2 | 0 add, 1 subtract, 2 multiply, 3 load binary |
| a_i | input | 15 | First operand, three one-hot residue fields |
| b_i | input | 15 | Second operand, three one-hot residue fields |
| bin_i | input | 7 | Binary value for the load operation |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 15 | Registered one-hot residue result |
| val_o | output | 7 | Binary value rebuilt from `res_o` |
| err_o | output | 3 | Per-channel malformed-operand flag |

## Verification
The properties assume only that the block starts from reset. They make no assumption about operand shape, because malformed one-hot fields are legal inputs with a defined outcome. The bench runs the three arithmetic operations on every pair of well-formed operands in 0..104, and the load operation on every 7-bit binary value, including the values above 104 that wrap. It also drives empty and multi-bit fields into each channel of each operand, so that the error-forcing rule is tested on purpose.

// File: rtl/ohrns_pkg.sv
package ohrns_pkg;
  localparam int NCH = 3;
  localparam int MODS [NCH] = '{3, 5, 7};

  function automatic int chan_off(int ch);
    int s = 0;
    for (int k = 0; k < ch; k++) s += MODS[k];
    return s;
  endfunction

  function automatic int range_prod();
    int p = 1;
    for (int k = 0; k < NCH; k++) p *= MODS[k];
    return p;
  endfunction

  localparam int TOT_W = chan_off(NCH);
  localparam int RANGE = range_prod();
  localparam int VAL_W = $clog2(RANGE);

  function automatic int mod_inv(int v, int m);
    for (int k = 1; k < m; k++) if ((v * k) % m == 1) return k;
    return 0;
  endfunction

  // CRT weight: (RANGE/m) * inverse(RANGE/m mod m), reduced mod RANGE
  function automatic int crt_weight(int ch);
    int q = RANGE / MODS[ch];
    return (q * mod_inv(q % MODS[ch], MODS[ch])) % RANGE;
  endfunction

  function automatic logic [TOT_W-1:0] zero_code();
    logic [TOT_W-1:0] v = '0;
    for (int k = 0; k < NCH; k++) v[chan_off(k)] = 1'b1;
    return v;
  endfunction

  localparam logic [TOT_W-1:0] ZERO_CODE = zero_code();

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_ENC = 2'd3
  } op_e;
endpackage

// File: rtl/ohrns_enc.sv
module ohrns_enc #(
  parameter int M    = 3,
  parameter int IN_W = 7
) (
  input  logic [IN_W-1:0] bin_i,
  output logic [M-1:0]    oh_o
);
  assign oh_o = M'(1) << (bin_i % IN_W'(M));
endmodule

// File: rtl/ohrns_chan.sv
module ohrns_chan
  import ohrns_pkg::*;
#(
  parameter int M = 3
) (
  input  logic [1:0]   op_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] res_o,
  output logic         err_o
);
  logic [M-1:0] add_v, sub_v, mul_v, raw_v;
  logic         ok;

  // b is one-hot: each set bit selects one fixed rewiring of a
  always_comb begin
    add_v = '0;
    sub_v = '0;
    mul_v = '0;
    for (int k = 0; k < M; k++) begin
      if (b_i[k]) begin
        for (int j = 0; j < M; j++) begin
          add_v[(j + k) % M]     |= a_i[j];
          sub_v[(j + M - k) % M] |= a_i[j];
          mul_v[(j * k) % M]     |= a_i[j];
        end
      end
    end
  end

  always_comb begin
    unique case (op_i)
      OP_ADD:  raw_v = add_v;
      OP_SUB:  raw_v = sub_v;
      default: raw_v = mul_v;
    endcase
  end

  assign ok    = $onehot(a_i) && $onehot(b_i);
  assign err_o = !ok;
  assign res_o = ok ? raw_v : M'(1);
endmodule

// File: rtl/ohrns_crt.sv
module ohrns_crt
  import ohrns_pkg::*;
(
  input  logic [TOT_W-1:0] oh_i,
  output logic [VAL_W-1:0] val_o
);
  localparam int SUM_W = $clog2(NCH * RANGE) + 1;

  logic [NCH*VAL_W-1:0] terms;
  logic [SUM_W-1:0]     acc;

  for (genvar c = 0; c < NCH; c++) begin : g_term
    localparam int OFF = chan_off(c);
    localparam int M   = MODS[c];
    localparam int WGT = crt_weight(c);
    logic [VAL_W-1:0] term;
    always_comb begin
      term = '0;
      for (int j = 0; j < M; j++)
        if (oh_i[OFF + j]) term |= VAL_W'((j * WGT) % RANGE);
    end
    assign terms[c*VAL_W +: VAL_W] = term;
  end

  always_comb begin
    acc = '0;
    for (int c = 0; c < NCH; c++) acc += SUM_W'(terms[c*VAL_W +: VAL_W]);
    for (int k = 0; k < NCH; k++)
      if (acc >= SUM_W'(RANGE)) acc -= SUM_W'(RANGE);
    val_o = acc[VAL_W-1:0];
  end
endmodule

// File: rtl/ohrns_alu.sv
module ohrns_alu
  import ohrns_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [TOT_W-1:0] a_i,
  input  logic [TOT_W-1:0] b_i,
  input  logic [VAL_W-1:0] bin_i,
  output logic             done_o,
  output logic [TOT_W-1:0] res_o,
  output logic [VAL_W-1:0] val_o,
  output logic [NCH-1:0]   err_o
);
  logic [TOT_W-1:0] nxt_res, res_q;
  logic [VAL_W-1:0] nxt_val, val_q;
  logic [NCH-1:0]   nxt_err, err_q;
  logic             done_q;
  logic             is_enc;

  assign is_enc = (op_i == OP_ENC);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int OFF = chan_off(i);
    localparam int M   = MODS[i];
    logic [M-1:0] ar_res, ld_res;
    logic         ar_err;

    ohrns_chan #(.M(M)) i_chan (
      .op_i  (op_i),
      .a_i   (a_i[OFF +: M]),
      .b_i   (b_i[OFF +: M]),
      .res_o (ar_res),
      .err_o (ar_err)
    );

    ohrns_enc #(.M(M), .IN_W(VAL_W)) i_enc (
      .bin_i (bin_i),
      .oh_o  (ld_res)
    );

    assign nxt_res[OFF +: M] = is_enc ? ld_res : ar_res;
    assign nxt_err[i]        = !is_enc && ar_err;
  end

  ohrns_crt i_crt (
    .oh_i  (nxt_res),
    .val_o (nxt_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= ZERO_CODE;
      val_q  <= '0;
      err_q  <= '0;
    end else begin
      done_q <= start_i;
      if (start_i) begin
        res_q <= nxt_res;
        val_q <= nxt_val;
        err_q <= nxt_err;
      end
    end
  end

  assign done_o = done_q;
  assign res_o  = res_q;
  assign val_o  = val_q;
  assign err_o  = err_q;
endmodule

// File: rtl/ohrns_alu_chk.sv
module ohrns_alu_chk
  import ohrns_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [1:0]       op_i,
  input logic             done_o,
  input logic [TOT_W-1:0] res_o,
  input logic [VAL_W-1:0] val_o,
  input logic [NCH-1:0]   err_o
);
  p_done_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  p_no_spurious_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(res_o) && $stable(val_o) && $stable(err_o)));

  p_load_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_ENC) |=> (err_o == '0));

  p_val_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_o < VAL_W'(RANGE));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int OFF = chan_off(i);
    localparam int M   = MODS[i];

    p_onehot_out_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(res_o[OFF +: M]) == 1);

    p_err_forces_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o[i] |-> (res_o[OFF +: M] == M'(1)));
  end
endmodule

bind ohrns_alu ohrns_alu_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .done_o  (done_o),
  .res_o   (res_o),
  .val_o   (val_o),
  .err_o   (err_o)
);

// File: tb/test_ohrns_alu.sv
`timescale 1ns/1ps
module test_ohrns_alu;
  localparam int BM [3] = '{3, 5, 7};
  localparam int BO [3] = '{0, 3, 8};
  localparam int N      = 105;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [14:0] a_i = '0;
  logic [14:0] b_i = '0;
  logic [6:0]  bin_i = '0;
  logic        done_o;
  logic [14:0] res_o;
  logic [6:0]  val_o;
  logic [2:0]  err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ohrns_alu i_ohrns_alu (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .bin_i(bin_i),
    .done_o(done_o), .res_o(res_o), .val_o(val_o), .err_o(err_o)
  );

  function automatic logic [14:0] enc(int x);
    logic [14:0] v = '0;
    for (int c = 0; c < 3; c++) v[BO[c] + (x % BM[c])] = 1'b1;
    return v;
  endfunction

  // integer in 0..104 whose residues match a one-hot word (search, not formula)
  function automatic int dec(logic [14:0] w);
    for (int z = 0; z < N; z++) if (enc(z) == w) return z;
    return -1;
  endfunction

  function automatic logic [14:0] set_field(logic [14:0] w, int c, logic [6:0] f);
    logic [14:0] v = w;
    for (int j = 0; j < BM[c]; j++) v[BO[c] + j] = f[j];
    return v;
  endfunction

  task automatic check(input string req, input logic [14:0] er, input int ev,
                       input logic [2:0] ee, input logic ed);
    n_chk++;
    if (res_o !== er || val_o !== 7'(ev) || err_o !== ee || done_o !== ed) begin
      n_fail++;
      $display("FAIL %s: got res=%h val=%0d err=%b done=%b, expected res=%h val=%0d err=%b done=%b",
               req, res_o, val_o, err_o, done_o, er, ev, ee, ed);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [14:0] a, input logic [14:0] b,
                        input logic [6:0] bin);
    op_i = op; a_i = a; b_i = b; bin_i = bin; start_i = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 15'h109, 0, 3'b000, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R3, R4, R5, R7, R2: all operand pairs
    for (int op = 0; op < 3; op++) begin
      for (int x = 0; x < N; x++) begin
        for (int y = 0; y < N; y++) begin
          int z;
          run_op(2'(op), enc(x), enc(y), 7'd0);
          z = (op == 0) ? (x + y) % N : (op == 1) ? (x - y + N) % N : (x * y) % N;
          check(op == 0 ? "R3" : op == 1 ? "R4" : "R5", enc(z), z, 3'b000, 1'b1);
        end
      end
    end

    // R6: load every 7-bit value, operands malformed but ignored
    for (int v = 0; v < 128; v++) begin
      run_op(2'd3, 15'h0000, 15'h7fff, 7'(v));
      check("R6", enc(v % N), v % N, 3'b000, 1'b1);
    end

    // R8: malformed fields per channel and operand
    for (int c = 0; c < 3; c++) begin
      for (int side = 0; side < 2; side++) begin
        for (int pat = 0; pat < 2; pat++) begin
          logic [14:0] a, b, er;
          logic [6:0]  f;
          f = (pat == 0) ? 7'b0000000 : 7'b0000011;
          a = enc(59);
          b = enc(23);
          if (side == 0) a = set_field(a, c, f);
          else           b = set_field(b, c, f);
          er = set_field(enc((59 + 23) % N), c, 7'b0000001);
          run_op(2'd0, a, b, 7'd0);
          check("R8", er, dec(er), 3'(1 << c), 1'b1);
        end
      end
    end

    // R9, R2: hold with start low while inputs move
    run_op(2'd2, enc(11), enc(8), 7'd0);
    check("R5", enc(88), 88, 3'b000, 1'b1);
    start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      op_i = 2'(k); a_i = enc(k + 40); b_i = 15'h0; bin_i = 7'(k + 3);
      @(negedge clk);
      check("R9", enc(88), 88, 3'b000, 1'b0);
    end

    // R1: asynchronous reset returns the idle state
    rst_ni = 1'b0;
    #3;
    check("R1", 15'h109, 0, 3'b000, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule